// File: doc/BRIEF.md
# Match/Capture Counter-Timer with PWM

A 32-bit counter-timer with a small register port. The count advances either once per clock or on chosen edges of an external capture pin. A count step happens only when the run bit is set and the hold-clear bit is not. Four compare registers watch the count. On a compare hit a channel can drive its output pin with a programmable action, reset the count, halt the counter, and raise a sticky interrupt flag. A configured edge on the capture pin copies the count into a capture register.

In PWM mode the first three channels become single-edge PWM outputs, and the last compare register sets the period. Software programs the compare values and actions, sets the run bit, and then reads the count, the capture value or the flags. Flags are cleared by writing ones to them.

Top module: `mct_timer`

## Requirements
- R1: After reset every register reads zero, the count is zero, and all match outputs and `irq` are low.
- R2: Register CTRL (address 0) has bit 0 = run and bit 1 = hold-clear. With run set and hold-clear low, the count advances. While hold-clear is set, the count stays at zero. With run low, the count holds its value.
- R3: The count source is chosen by CNTSRC[4:3] (address 4): 00 = every clock, 01 = rising edges of the synchronized capture pin, 10 = falling edges, 11 = both edges.
- R4: A hit on channel i happens on a count step taken while the count equals MATCHi (address 8+i). If MCTRL (address 2) bit 3i+1 is set, the hit makes the count 0 instead of count+1. If bit 3i+2 is set, the hit leaves the count unchanged and clears the run bit.
- R5: On a hit, channel i drives its output according to ACT (address 3) bits [2i+1:2i]: 00 = no change, 01 = low, 10 = high, 11 = toggle.
- R6: The capture pin passes through two synchronizer flops. Its rising edge (CNTSRC bit 0) or falling edge (CNTSRC bit 1) copies the count into CAP (address 7). A disabled edge leaves CAP unchanged.
- R7: FLAGS (address 6) bit i is set by a hit on channel i, and bit 4 is set by a capture. Flags stay set until 1 is written to them. `irq` is high when a flag is set and its enable is set: MCTRL bit 3i for a channel, CNTSRC bit 2 for capture.
- R8: PWM enable bits PWMEN[2:0] (address 5) apply to channels 0 to 2. An enabled output goes low at a hit on channel 3 and high at its own hit, so the high time is MATCH3 − MATCHi counts. A compare value of zero keeps the output high. While any PWM bit is set, a channel-3 hit resets the count.
- R9: `rdata` shows the register at `addr` one clock after `addr` is applied. COUNT (address 1) and CAP are read-only, so writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cap_in | input | 1 | Capture / external count pin (asynchronous) |
| match_out | output | 4 | Registered match output pins |
| irq | output | 1 | Registered interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. `rdata` is due one clock after the address is applied, and the bench compares it at the next falling edge. A count step in clock mode, and the hit, output action, flag and stop it causes, all land on the same edge. `irq` follows its flag one edge later. An edge on `cap_in` reaches the counter or CAP on the third edge after it is applied. The bench therefore waits at least five cycles after any pin change, and reads counts only after the counter has stopped on a hit, so each value read is fixed. PWM duty is measured over 20 consecutive cycles after settling, which is two whole periods.

// File: rtl/mct_pkg.sv
package mct_pkg;
  // register addresses
  localparam int A_CTRL   = 0;
  localparam int A_COUNT  = 1;
  localparam int A_MCTRL  = 2;
  localparam int A_ACT    = 3;
  localparam int A_CNTSRC = 4;
  localparam int A_PWMEN  = 5;
  localparam int A_FLAGS  = 6;
  localparam int A_CAP    = 7;
  localparam int A_MATCH0 = 8;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } ext_act_e;
endpackage

// File: rtl/mct_edge.sv
module mct_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;
  logic            cur, prev;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign cur  = sh[STAGES-1];
  assign prev = sh[STAGES];
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
endmodule

// File: rtl/mct_counter.sv
module mct_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             rst_hit,
  input  logic             stop_hit,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (tick) begin
      if (rst_hit)        count <= '0;
      else if (!stop_hit) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/mct_match.sv
module mct_match import mct_pkg::*; #(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            tick,
  input  logic [CNT_W-1:0]                count,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] mr,
  input  logic [2*NUM_MATCH-1:0]          act,
  input  logic [NUM_MATCH-2:0]            pwm_en,
  output logic [NUM_MATCH-1:0]            hit,
  output logic [NUM_MATCH-1:0]            out
);
  localparam int PER = NUM_MATCH - 1;

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_ch
    logic     hit_c, out_r, pwm_on;
    ext_act_e act_c;

    assign hit_c  = tick && (count == mr[i]);
    assign act_c  = ext_act_e'(act[2*i +: 2]);
    assign hit[i] = hit_c;
    assign out[i] = out_r;

    if (i < PER) begin : g_pwm
      assign pwm_on = pwm_en[i];
    end else begin : g_nopwm
      assign pwm_on = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) out_r <= 1'b0;
      else if (pwm_on) begin
        if (hit[PER])   out_r <= (mr[i] == '0);
        else if (hit_c) out_r <= 1'b1;
      end else if (hit_c) begin
        case (act_c)
          ACT_CLR: out_r <= 1'b0;
          ACT_SET: out_r <= 1'b1;
          ACT_TGL: out_r <= ~out_r;
          default: out_r <= out_r;
        endcase
      end
    end
  end
endmodule

// File: rtl/mct_timer.sv
module mct_timer import mct_pkg::*; #(
  parameter int CNT_W       = 32,
  parameter int NUM_MATCH   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CNT_W-1:0]     wdata,
  output logic [CNT_W-1:0]     rdata,
  input  logic                 cap_in,
  output logic [NUM_MATCH-1:0] match_out,
  output logic                 irq
);
  localparam int NM  = NUM_MATCH;
  localparam int MCW = 3 * NM;
  localparam int ACW = 2 * NM;
  localparam int FLW = NM + 1;

  logic                     ctrl_en, ctrl_rst;
  logic [MCW-1:0]           mctrl;
  logic [ACW-1:0]           act;
  logic [4:0]               cntsrc;
  logic [NM-2:0]            pwmen;
  logic [FLW-1:0]           flags;
  logic [CNT_W-1:0]         cap_reg, count, rd_mux;
  logic [NM-1:0][CNT_W-1:0] mr;
  logic [NM-1:0]            hit, irq_on, rst_on, stop_on, rst_sel;
  logic                     rise, fall, tick, cap_pulse, rst_hit, stop_hit;
  logic                     wr_ctrl, wr_flags;

  assign wr_ctrl  = wr_en && (addr == ADDR_W'(A_CTRL));
  assign wr_flags = wr_en && (addr == ADDR_W'(A_FLAGS));

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      irq_on[i]  = mctrl[3*i];
      rst_on[i]  = mctrl[3*i+1];
      stop_on[i] = mctrl[3*i+2];
    end
    rst_sel         = rst_on;
    rst_sel[NM-1]   = rst_on[NM-1] | (|pwmen);
  end

  assign rst_hit   = |(hit & rst_sel);
  assign stop_hit  = |(hit & stop_on);
  assign cap_pulse = (rise & cntsrc[0]) | (fall & cntsrc[1]);
  assign tick      = ctrl_en && !ctrl_rst &&
                     ((cntsrc[4:3] == 2'b00) || (rise && cntsrc[3]) || (fall && cntsrc[4]));

  mct_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .din(cap_in), .rise(rise), .fall(fall)
  );

  mct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(ctrl_rst), .tick(tick),
    .rst_hit(rst_hit), .stop_hit(stop_hit), .count(count)
  );

  mct_match #(.CNT_W(CNT_W), .NUM_MATCH(NM)) u_match (
    .clk(clk), .rst(rst), .tick(tick), .count(count), .mr(mr),
    .act(act), .pwm_en(pwmen), .hit(hit), .out(match_out)
  );

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      ctrl_rst <= 1'b0;
      mctrl    <= '0;
      act      <= '0;
      cntsrc   <= '0;
      pwmen    <= '0;
      mr       <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en  <= wdata[0];
        ctrl_rst <= wdata[1];
      end else if (stop_hit) begin
        ctrl_en  <= 1'b0;
      end
      if (wr_en && addr == ADDR_W'(A_MCTRL))  mctrl  <= wdata[MCW-1:0];
      if (wr_en && addr == ADDR_W'(A_ACT))    act    <= wdata[ACW-1:0];
      if (wr_en && addr == ADDR_W'(A_CNTSRC)) cntsrc <= wdata[4:0];
      if (wr_en && addr == ADDR_W'(A_PWMEN))  pwmen  <= wdata[NM-2:0];
      for (int i = 0; i < NM; i++) begin
        if (wr_en && addr == ADDR_W'(A_MATCH0 + i)) mr[i] <= wdata;
      end
    end
  end

  // capture, flags, interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_reg <= '0;
      flags   <= '0;
      irq     <= 1'b0;
    end else begin
      if (cap_pulse) cap_reg <= count;
      flags <= (flags & ~(wr_flags ? wdata[FLW-1:0] : '0)) | {cap_pulse, hit};
      irq   <= |(flags & {cntsrc[2], irq_on});
    end
  end

  // read port
  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(A_CTRL):   rd_mux[1:0]     = {ctrl_rst, ctrl_en};
      ADDR_W'(A_COUNT):  rd_mux          = count;
      ADDR_W'(A_MCTRL):  rd_mux[MCW-1:0] = mctrl;
      ADDR_W'(A_ACT):    rd_mux[ACW-1:0] = act;
      ADDR_W'(A_CNTSRC): rd_mux[4:0]     = cntsrc;
      ADDR_W'(A_PWMEN):  rd_mux[NM-2:0]  = pwmen;
      ADDR_W'(A_FLAGS):  rd_mux[FLW-1:0] = flags;
      ADDR_W'(A_CAP):    rd_mux          = cap_reg;
      default: begin
        for (int i = 0; i < NM; i++) begin
          if (addr == ADDR_W'(A_MATCH0 + i)) rd_mux = mr[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk import mct_pkg::*; #(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 4,
  parameter int ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic                 ctrl_en,
  input logic                 ctrl_rst,
  input logic [CNT_W-1:0]     count,
  input logic [CNT_W-1:0]     cap_reg,
  input logic                 cap_pulse,
  input logic [NUM_MATCH-1:0] hit,
  input logic [NUM_MATCH-1:0] stop_on,
  input logic [NUM_MATCH-1:0] rst_sel,
  input logic [NUM_MATCH:0]   flags
);
  // R2: hold-clear keeps the count at zero
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
    ctrl_rst |=> count == '0);

  // R2: run low freezes the count
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !ctrl_rst) |=> count == $past(count));

  // R4: stop-on-hit clears the run bit
  a_r4_stop_clears_run: assert property (@(posedge clk) disable iff (rst)
    ((|(hit & stop_on)) && !(wr_en && addr == ADDR_W'(A_CTRL))) |=> !ctrl_en);

  // R4 / R8: reset-on-hit returns the count to zero
  a_r4_reset_to_zero: assert property (@(posedge clk) disable iff (rst)
    (|(hit & rst_sel)) |=> count == '0);

  // R6: capture copies the count seen at the capture edge
  a_r6_capture_copy: assert property (@(posedge clk) disable iff (rst)
    cap_pulse |=> cap_reg == $past(count));

  // R7: flags only drop through a write to the flag register
  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(A_FLAGS)) |=> (flags & $past(flags)) == $past(flags));
endmodule

bind mct_timer mct_timer_chk #(
  .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .ctrl_en(ctrl_en), .ctrl_rst(ctrl_rst), .count(count), .cap_reg(cap_reg),
  .cap_pulse(cap_pulse), .hit(hit), .stop_on(stop_on), .rst_sel(rst_sel),
  .flags(flags)
);

// File: tb/mct_timer_tb_top.sv
module mct_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cap_in = 1'b0;
  logic [3:0]  match_out;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mct_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .match_out(match_out), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer than 20000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input int req, input string what);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    check(req, rdata, exp, what);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cap_in = 1'b1;
      idle(4);
      cap_in = 1'b0;
      idle(4);
    end
  endtask

  // vector: {req[3:0], op[1:0], addr[3:0], data[31:0]}
  // op 0 write, 1 read and compare, 2 idle data cycles, 3 compare {irq, match_out}
  localparam int NV = 38;
  localparam logic [41:0] VEC [NV] = '{
    {4'd1, 2'd1, 4'd0,  32'h0},    // R1 CTRL reset value
    {4'd1, 2'd1, 4'd1,  32'h0},    // R1 COUNT reset value
    {4'd1, 2'd3, 4'd0,  32'h0},    // R1 pins low
    {4'd9, 2'd0, 4'd9,  32'h100},
    {4'd9, 2'd0, 4'd10, 32'h100},
    {4'd9, 2'd0, 4'd11, 32'h100},
    {4'd9, 2'd0, 4'd8,  32'd5},
    {4'd4, 2'd0, 4'd2,  32'h5},    // ch0 irq enable + stop
    {4'd5, 2'd0, 4'd3,  32'h2},    // ch0 set
    {4'd9, 2'd1, 4'd8,  32'd5},    // R9 readback MATCH0
    {4'd2, 2'd0, 4'd0,  32'h1},    // run
    {4'd2, 2'd2, 4'd0,  32'd10},
    {4'd4, 2'd1, 4'd1,  32'd5},    // R4 stop holds count at 5
    {4'd7, 2'd1, 4'd6,  32'h1},    // R7 flag 0
    {4'd4, 2'd1, 4'd0,  32'h0},    // R4 run bit cleared
    {4'd5, 2'd3, 4'd0,  32'h11},   // R5 set action, R7 irq
    {4'd7, 2'd0, 4'd6,  32'h1},
    {4'd7, 2'd1, 4'd6,  32'h0},    // R7 write-one clears
    {4'd7, 2'd3, 4'd0,  32'h01},   // R7 irq drops
    {4'd2, 2'd0, 4'd0,  32'h2},
    {4'd2, 2'd0, 4'd0,  32'h0},
    {4'd2, 2'd1, 4'd1,  32'h0},    // R2 hold-clear zeroed count
    {4'd9, 2'd0, 4'd1,  32'h55},
    {4'd9, 2'd1, 4'd1,  32'h0},    // R9 COUNT read-only
    {4'd4, 2'd0, 4'd9,  32'd3},
    {4'd4, 2'd0, 4'd2,  32'h30},   // ch1 reset + stop
    {4'd5, 2'd0, 4'd3,  32'hC},    // ch1 toggle
    {4'd4, 2'd0, 4'd0,  32'h1},
    {4'd4, 2'd2, 4'd0,  32'd8},
    {4'd4, 2'd1, 4'd1,  32'h0},    // R4 reset-on-hit
    {4'd4, 2'd1, 4'd0,  32'h0},    // R4 stop with reset
    {4'd5, 2'd3, 4'd0,  32'h03},   // R5 toggle high
    {4'd7, 2'd1, 4'd6,  32'h2},    // R7 flag 1
    {4'd5, 2'd0, 4'd0,  32'h1},
    {4'd5, 2'd2, 4'd0,  32'd8},
    {4'd5, 2'd3, 4'd0,  32'h01},   // R5 toggle back low
    {4'd7, 2'd0, 4'd6,  32'h1F},
    {4'd7, 2'd1, 4'd6,  32'h0}     // R7 all flags clear
  };

  initial begin
    idle(4);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic [3:0]  rq;
      logic [1:0]  op;
      logic [3:0]  a;
      logic [31:0] d;
      {rq, op, a, d} = VEC[v];
      case (op)
        2'd0: wr(a, d);
        2'd1: rd(a, d, int'(rq), $sformatf("vector %0d read addr %0d", v, a));
        2'd2: idle(int'(d));
        default: begin
          @(negedge clk);
          check(int'(rq), {27'd0, irq, match_out}, d, $sformatf("vector %0d pins", v));
        end
      endcase
    end

    // R6 capture edges
    wr(4'd8, 32'd7);
    wr(4'd2, 32'h4);          // ch0 stop only
    wr(4'd3, 32'h0);
    wr(4'd0, 32'h1);
    idle(12);
    wr(4'd6, 32'h1F);
    wr(4'd4, 32'h5);          // rising capture, capture irq
    @(negedge clk); cap_in = 1'b1;
    idle(5);
    rd(4'd7, 32'd7, 6, "rising edge capture");
    rd(4'd6, 32'h10, 7, "capture flag");
    @(negedge clk);
    check(7, {27'd0, irq, match_out}, 32'h11, "capture irq");
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h0);
    @(negedge clk); cap_in = 1'b0;
    idle(5);
    rd(4'd7, 32'd7, 6, "falling edge ignored when rising selected");
    wr(4'd4, 32'h2);          // falling only
    @(negedge clk); cap_in = 1'b1;
    idle(5);
    rd(4'd7, 32'd7, 6, "rising edge ignored when falling selected");
    @(negedge clk); cap_in = 1'b0;
    idle(5);
    rd(4'd7, 32'd0, 6, "falling edge capture");
    wr(4'd6, 32'h1F);

    // R3 external count sources
    wr(4'd4, 32'h08);
    wr(4'd0, 32'h1);
    pulses(3);
    idle(6);
    rd(4'd1, 32'd3, 3, "count on rising edges");
    wr(4'd4, 32'h18);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h1);
    pulses(2);
    idle(6);
    rd(4'd1, 32'd4, 3, "count on both edges");
    wr(4'd4, 32'h10);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h1);
    pulses(2);
    idle(6);
    rd(4'd1, 32'd2, 3, "count on falling edges");

    // R8 PWM
    wr(4'd4, 32'h0);
    wr(4'd0, 32'h2);
    wr(4'd2, 32'h0);
    wr(4'd11, 32'd9);
    wr(4'd8, 32'd3);
    wr(4'd9, 32'd0);
    wr(4'd10, 32'd7);
    wr(4'd5, 32'h7);
    wr(4'd0, 32'h1);
    idle(25);
    begin
      int h0 = 0, h1 = 0, h2 = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        h0 += int'(match_out[0]);
        h1 += int'(match_out[1]);
        h2 += int'(match_out[2]);
      end
      check(8, h0, 12, "pwm ch0 high cycles in 20");
      check(8, h1, 20, "pwm ch1 zero value stays high");
      check(8, h2, 4,  "pwm ch2 high cycles in 20");
    end
    @(negedge clk);
    addr = 4'd1;
    @(negedge clk);
    check(8, {31'd0, rdata < 32'd10}, 32'd1, "pwm period bounds count");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule